// File: doc/BRIEF.md
# PHY Test-Port Bus Master

This block turns simple read and write commands into the bit-level sequences that a physical-layer macro's 8-bit test and configuration port expects. That port has a test clock, a test enable, a test clear, a parallel data input to the PHY and a parallel data output from the PHY. A write sends a test code followed by a data byte and returns the byte the PHY shows on its output afterwards. A read sends a test code, returns the byte the PHY then shows, and writes that same byte back as the data phase, so the addressed register keeps its value.

Two PHY test ports hang off the block. A select field chosen with each command decides which port a sequence drives. The other port's pins keep their levels. Every pin change is followed by a hold of a parameterised number of system clocks before the next step, so the PHY sees slow, well-separated edges. Raising and releasing test clear are commands of their own.

Commands enter through a valid/ready handshake. The block holds one command at a time. A one-cycle response strobe ends each command.

Top module: `tport_master`

## Requirements
- R1: After reset every test clock, test enable, test clear and data-input pin of both ports is low, `cmdReady` is high, and `busy` and `rspValid` are low.
- R2: The code phase changes the selected port's pins in this order, each step being a no-op when the pin already has that level: test clock high, data input = code byte, test enable high, test clock low, test enable low. Test enable rises only while test clock is high, and falls only while test clock is low.
- R3: The data phase follows the code phase and does this, in order: test clock low, data input = data byte, test clock high.
- R4: A write (`cmdOp` = 1) returns on `rspData` the PHY output byte sampled after the data phase has ended.
- R5: A read (`cmdOp` = 0) samples the PHY output byte after the code phase, returns it on `rspData`, and uses that byte as the data-input value of its data phase.
- R6: Any two successive pin changes are at least HOLD_CYC+1 clock cycles apart. A write or read takes exactly 8*(HOLD_CYC+1)+2 cycles from the accepting edge to the `rspValid` cycle.
- R7: `cmdSel` (0 or 1) picks the port that the command drives. No pin of the other port changes.
- R8: `cmdOp` = 2 raises test clear and `cmdOp` = 3 lowers it on the selected port. Each changes only that pin and gives `rspValid` HOLD_CYC+2 cycles after the accepting edge.
- R9: `busy` is high from the cycle after acceptance through the single cycle in which `rspValid` is high, and `rspValid` is never high for two cycles in a row.
- R10: While a command is in progress `cmdReady` stays low. A command held valid meanwhile is accepted only after the response, and its fields do not affect the sequence that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle, command taken on this edge |
| cmdOp | input | 2 | 0 read, 1 write, 2 clear raise, 3 clear release |
| cmdSel | input | 1 | Target test port |
| cmdCode | input | 8 | Test code byte |
| cmdData | input | 8 | Data byte for writes |
| busy | output | 1 | Command in progress |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 8 | Sampled PHY output byte |
| tstClk | output | 2 | Test clock, one bit per port |
| tstEn | output | 2 | Test enable, one bit per port |
| tstClr | output | 2 | Test clear, one bit per port |
| tstDin | output | 16 | Data into each PHY, port p at bits 8p+7..8p |
| tstDout | input | 16 | Data from each PHY, port p at bits 8p+7..8p |

## Verification
The bench puts a behavioural PHY behind each port. The PHY latches the code on a falling test clock with enable high, and stores data on a rising clock with enable low. The bench logs every pin edge and compares the log with the order it builds from the requirements. A design that swapped the clock and enable steps would latch the wrong address and return wrong bytes. A read that did not drive back the sampled byte would corrupt the register, and a later read shows this. The bench also checks that the unselected port stays quiet, that edges keep their spacing and that the latencies are exact. A second command held valid during a sequence exposes a block that accepts early or that takes live input fields instead of the latched ones.

// File: rtl/tport_pkg.sv
package tport_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_CLR_SET = 2'd2,
    OP_CLR_REL = 2'd3
  } opT;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_C_CLKHI,
    ST_C_DIN,
    ST_C_ENHI,
    ST_C_CLKLO,
    ST_C_ENLO,
    ST_RD_SAMPLE,
    ST_D_CLKLO,
    ST_D_DIN,
    ST_D_CLKHI,
    ST_WR_SAMPLE,
    ST_CLR_HI,
    ST_CLR_LO,
    ST_DONE
  } stepT;

  // strobes from control to datapath, one per pin action
  typedef struct packed {
    logic load;
    logic clkHi;
    logic clkLo;
    logic enHi;
    logic enLo;
    logic clrHi;
    logic clrLo;
    logic dinCode;
    logic dinData;
    logic dinCapt;
    logic capture;
  } strobeT;

endpackage

// File: rtl/tport_ctrl.sv
module tport_ctrl
  import tport_pkg::*;
#(
  parameter int HOLD_CYC = 250,
  localparam int CntW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output logic       cmdReady,
  output logic       busy,
  output logic       rspValid,
  output strobeT     strb
);

  stepT            state, stateNxt;
  opT              opQ;
  logic [CntW-1:0] cnt, cntNxt;
  logic            isPin;

  function automatic stepT nextStep(stepT s, opT o);
    case (s)
      ST_C_CLKHI: nextStep = ST_C_DIN;
      ST_C_DIN:   nextStep = ST_C_ENHI;
      ST_C_ENHI:  nextStep = ST_C_CLKLO;
      ST_C_CLKLO: nextStep = ST_C_ENLO;
      ST_C_ENLO:  nextStep = (o == OP_READ) ? ST_RD_SAMPLE : ST_D_CLKLO;
      ST_D_CLKLO: nextStep = ST_D_DIN;
      ST_D_DIN:   nextStep = ST_D_CLKHI;
      ST_D_CLKHI: nextStep = (o == OP_READ) ? ST_DONE : ST_WR_SAMPLE;
      default:    nextStep = ST_DONE;
    endcase
  endfunction

  always_comb begin
    case (state)
      ST_C_CLKHI, ST_C_DIN, ST_C_ENHI, ST_C_CLKLO, ST_C_ENLO,
      ST_D_CLKLO, ST_D_DIN, ST_D_CLKHI, ST_CLR_HI, ST_CLR_LO: isPin = 1'b1;
      default: isPin = 1'b0;
    endcase
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    cntNxt   = cnt;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          strb.load = 1'b1;
          cntNxt    = '0;
          case (opT'(cmdOp))
            OP_CLR_SET: stateNxt = ST_CLR_HI;
            OP_CLR_REL: stateNxt = ST_CLR_LO;
            default:    stateNxt = ST_C_CLKHI;
          endcase
        end
      end
      ST_RD_SAMPLE: begin
        strb.capture = 1'b1;
        stateNxt     = ST_D_CLKLO;
      end
      ST_WR_SAMPLE: begin
        strb.capture = 1'b1;
        stateNxt     = ST_DONE;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: begin
        if (isPin) begin
          if (cnt == '0) begin
            case (state)
              ST_C_CLKHI, ST_D_CLKHI: strb.clkHi = 1'b1;
              ST_C_CLKLO, ST_D_CLKLO: strb.clkLo = 1'b1;
              ST_C_ENHI:              strb.enHi  = 1'b1;
              ST_C_ENLO:              strb.enLo  = 1'b1;
              ST_C_DIN:               strb.dinCode = 1'b1;
              ST_D_DIN: begin
                if (opQ == OP_READ) strb.dinCapt = 1'b1;
                else                strb.dinData = 1'b1;
              end
              ST_CLR_HI:              strb.clrHi = 1'b1;
              ST_CLR_LO:              strb.clrLo = 1'b1;
              default: ;
            endcase
          end
          if (cnt == CntW'(HOLD_CYC)) begin
            cntNxt   = '0;
            stateNxt = nextStep(state, opQ);
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end else begin
          stateNxt = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_READ;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (strb.load) opQ <= opT'(cmdOp);
    end
  end

  assign cmdReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign rspValid = (state == ST_DONE);

endmodule

// File: rtl/tport_dpath.sv
module tport_dpath
  import tport_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NPORT = 2,
  localparam int SelW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic [SelW-1:0]     cmdSel,
  input  logic [DW-1:0]       cmdCode,
  input  logic [DW-1:0]       cmdData,
  input  logic [NPORT*DW-1:0] tstDout,
  output logic [DW-1:0]       rspData,
  output logic [NPORT-1:0]    tstClk,
  output logic [NPORT-1:0]    tstEn,
  output logic [NPORT-1:0]    tstClr,
  output logic [NPORT*DW-1:0] tstDin
);

  logic [SelW-1:0] selQ;
  logic [DW-1:0]   codeQ, dataQ, captQ;
  logic [DW-1:0]   doutSel;

  always_comb begin
    doutSel = '0;
    for (int p = 0; p < NPORT; p++)
      if (selQ == SelW'(p)) doutSel = tstDout[p*DW +: DW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      codeQ <= '0;
      dataQ <= '0;
      captQ <= '0;
    end else begin
      if (strb.load) begin
        selQ  <= cmdSel;
        codeQ <= cmdCode;
        dataQ <= cmdData;
      end
      if (strb.capture) captQ <= doutSel;
    end
  end

  assign rspData = captQ;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic          clkR, enR, clrR;
    logic [DW-1:0] dinR;
    logic          hit;

    assign hit = (selQ == SelW'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkR <= 1'b0;
        enR  <= 1'b0;
        clrR <= 1'b0;
        dinR <= '0;
      end else if (hit) begin
        if (strb.clkHi) clkR <= 1'b1;
        if (strb.clkLo) clkR <= 1'b0;
        if (strb.enHi)  enR  <= 1'b1;
        if (strb.enLo)  enR  <= 1'b0;
        if (strb.clrHi) clrR <= 1'b1;
        if (strb.clrLo) clrR <= 1'b0;
        if (strb.dinCode)      dinR <= codeQ;
        else if (strb.dinData) dinR <= dataQ;
        else if (strb.dinCapt) dinR <= captQ;
      end
    end

    assign tstClk[p]          = clkR;
    assign tstEn[p]           = enR;
    assign tstClr[p]          = clrR;
    assign tstDin[p*DW +: DW] = dinR;
  end

endmodule

// File: rtl/tport_master.sv
module tport_master
  import tport_pkg::*;
#(
  parameter int HOLD_CYC = 250,
  parameter int DW       = 8,
  parameter int NPORT    = 2,
  localparam int SelW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [1:0]          cmdOp,
  input  logic [SelW-1:0]     cmdSel,
  input  logic [DW-1:0]       cmdCode,
  input  logic [DW-1:0]       cmdData,
  output logic                busy,
  output logic                rspValid,
  output logic [DW-1:0]       rspData,
  output logic [NPORT-1:0]    tstClk,
  output logic [NPORT-1:0]    tstEn,
  output logic [NPORT-1:0]    tstClr,
  output logic [NPORT*DW-1:0] tstDin,
  input  logic [NPORT*DW-1:0] tstDout
);

  strobeT strb;

  tport_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdReady (cmdReady),
    .busy     (busy),
    .rspValid (rspValid),
    .strb     (strb)
  );

  tport_dpath #(.DW(DW), .NPORT(NPORT)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdSel  (cmdSel),
    .cmdCode (cmdCode),
    .cmdData (cmdData),
    .tstDout (tstDout),
    .rspData (rspData),
    .tstClk  (tstClk),
    .tstEn   (tstEn),
    .tstClr  (tstClr),
    .tstDin  (tstDin)
  );

endmodule

// File: rtl/tport_master_chk.sv
module tport_master_chk #(
  parameter int HOLD_CYC = 250,
  parameter int DW       = 8,
  parameter int NPORT    = 2,
  localparam int SelW    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int GapW    = $clog2(HOLD_CYC + 2) + 1,
  localparam int PinW    = DW + 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                cmdReady,
  input logic [SelW-1:0]     cmdSel,
  input logic                busy,
  input logic                rspValid,
  input logic [NPORT-1:0]    tstClk,
  input logic [NPORT-1:0]    tstEn,
  input logic [NPORT-1:0]    tstClr,
  input logic [NPORT*DW-1:0] tstDin
);

  logic [NPORT*PinW-1:0] curPins, prevPins;
  logic [GapW-1:0]       gapCnt;
  logic [SelW-1:0]       selSeen;
  logic                  anyChg;

  always_comb
    for (int p = 0; p < NPORT; p++)
      curPins[p*PinW +: PinW] = {tstClk[p], tstEn[p], tstClr[p], tstDin[p*DW +: DW]};

  assign anyChg = (curPins != prevPins);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPins <= '0;
      gapCnt   <= GapW'(HOLD_CYC);
      selSeen  <= '0;
    end else begin
      prevPins <= curPins;
      if (anyChg) gapCnt <= '0;
      else if (gapCnt < GapW'(HOLD_CYC)) gapCnt <= gapCnt + 1'b1;
      if (cmdValid && cmdReady) selSeen <= cmdSel;
    end
  end

  p_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    anyChg |-> (gapCnt >= GapW'(HOLD_CYC)));

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_rsp_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> busy);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (busy && !cmdReady));

  p_busy_noready_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmdReady);

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    p_en_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(tstEn[p]) |-> tstClk[p]);

    p_en_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(tstEn[p]) |-> !tstClk[p]);

    p_din_en_low_r3: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(tstDin[p*DW +: DW]) |-> !tstEn[p]);

    p_unsel_r7: assert property (@(posedge clk) disable iff (!rstN)
      (busy && selSeen != SelW'(p)) |-> $stable(curPins[p*PinW +: PinW]));
  end

endmodule

bind tport_master tport_master_chk #(
  .HOLD_CYC (HOLD_CYC),
  .DW       (DW),
  .NPORT    (NPORT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdSel   (cmdSel),
  .busy     (busy),
  .rspValid (rspValid),
  .tstClk   (tstClk),
  .tstEn    (tstEn),
  .tstClr   (tstClr),
  .tstDin   (tstDin)
);

// File: tb/tport_master_tb.sv
`timescale 1ns/1ps
module tport_master_tb;

  localparam int HOLD = 3;
  localparam int LAT_RW = 8 * (HOLD + 1) + 2;
  localparam int LAT_CLR = HOLD + 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = 2'd0;
  logic [0:0]  cmdSel = 1'b0;
  logic [7:0]  cmdCode = 8'h00;
  logic [7:0]  cmdData = 8'h00;
  logic        busy, rspValid;
  logic [7:0]  rspData;
  logic [1:0]  tstClk, tstEn, tstClr;
  logic [15:0] tstDin, tstDout;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;

  tport_master #(.HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdSel(cmdSel), .cmdCode(cmdCode), .cmdData(cmdData),
    .busy(busy), .rspValid(rspValid), .rspData(rspData),
    .tstClk(tstClk), .tstEn(tstEn), .tstClr(tstClr),
    .tstDin(tstDin), .tstDout(tstDout)
  );

  // behavioural PHY per port: code latched on falling clock with enable high,
  // data stored on rising clock with enable low, output shows addressed register
  for (genvar p = 0; p < 2; p++) begin : g_phy
    logic [7:0] mem [256];
    logic [7:0] addr;
    initial begin
      addr = 8'h00;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    end
    always @(posedge tstClk[p]) if (!tstEn[p]) mem[addr] = tstDin[p*8 +: 8];
    always @(negedge tstClk[p]) if (tstEn[p]) addr = tstDin[p*8 +: 8];
    always @(posedge tstClr[p]) addr = 8'h00;
    assign tstDout[p*8 +: 8] = mem[addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // event logs: kind*1000 + value (1 clk, 2 en, 3 clr, 4 din)
  int actLog [2][64];
  int actN [2];
  int expLog [2][64];
  int expN [2];
  int lastCyc [2];
  logic [1:0] prvClk = 2'b00, prvEn = 2'b00, prvClr = 2'b00;
  logic [15:0] prvDin = 16'h0;
  logic [1:0] eClk = 2'b00, eEn = 2'b00, eClr = 2'b00;
  logic [7:0] eDin [2] = '{8'h00, 8'h00};

  initial begin
    for (int p = 0; p < 2; p++) begin
      actN[p] = 0;
      expN[p] = 0;
      lastCyc[p] = -1000;
    end
  end

  task automatic logEv(input int p, input int ev);
    if (cyc - lastCyc[p] < HOLD + 1)
      chk(1'b0, "R6", "pin change spacing", cyc - lastCyc[p], HOLD + 1);
    else
      chk(1'b1, "R6", "pin change spacing", 0, 0);
    lastCyc[p] = cyc;
    if (actN[p] < 64) actLog[p][actN[p]] = ev;
    actN[p]++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      for (int p = 0; p < 2; p++) begin
        if (tstClk[p] != prvClk[p]) logEv(p, 1000 + int'(tstClk[p]));
        if (tstEn[p] != prvEn[p])   logEv(p, 2000 + int'(tstEn[p]));
        if (tstClr[p] != prvClr[p]) logEv(p, 3000 + int'(tstClr[p]));
        if (tstDin[p*8 +: 8] != prvDin[p*8 +: 8]) logEv(p, 4000 + int'(tstDin[p*8 +: 8]));
      end
    end
    prvClk = tstClk; prvEn = tstEn; prvClr = tstClr; prvDin = tstDin;
  end

  task automatic expPush(input int p, input int ev);
    if (expN[p] < 64) expLog[p][expN[p]] = ev;
    expN[p]++;
  endtask

  task automatic eSetClk(input int p, input logic v);
    if (eClk[p] != v) begin eClk[p] = v; expPush(p, 1000 + int'(v)); end
  endtask
  task automatic eSetEn(input int p, input logic v);
    if (eEn[p] != v) begin eEn[p] = v; expPush(p, 2000 + int'(v)); end
  endtask
  task automatic eSetClr(input int p, input logic v);
    if (eClr[p] != v) begin eClr[p] = v; expPush(p, 3000 + int'(v)); end
  endtask
  task automatic eSetDin(input int p, input logic [7:0] v);
    if (eDin[p] != v) begin eDin[p] = v; expPush(p, 4000 + int'(v)); end
  endtask

  // R2 code phase followed by R3 data phase
  task automatic expSeq(input int p, input logic [7:0] code, input logic [7:0] dat);
    eSetClk(p, 1'b1); eSetDin(p, code); eSetEn(p, 1'b1); eSetClk(p, 1'b0); eSetEn(p, 1'b0);
    eSetClk(p, 1'b0); eSetDin(p, dat); eSetClk(p, 1'b1);
  endtask

  task automatic clearLogs();
    for (int p = 0; p < 2; p++) begin actN[p] = 0; expN[p] = 0; end
  endtask

  task automatic cmpLogs(input string req);
    for (int p = 0; p < 2; p++) begin
      chk(actN[p] == expN[p], req, $sformatf("event count port %0d", p), actN[p], expN[p]);
      for (int i = 0; i < expN[p] && i < actN[p] && i < 64; i++)
        chk(actLog[p][i] == expLog[p][i], req, $sformatf("event %0d port %0d", i, p),
            actLog[p][i], expLog[p][i]);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input logic sel, input logic [7:0] code,
                       input logic [7:0] dat, output logic [7:0] rsp, output int lat);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdSel = sel; cmdCode = code; cmdData = dat;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 1;
    chk(busy && !cmdReady, "R9", "busy after accept", {busy, cmdReady}, 2'b10);
    while (!rspValid && lat < 200) begin @(negedge clk); lat++; end
    rsp = rspData;
    chk(busy, "R9", "busy with response", busy, 1);
    @(negedge clk);
    chk(!rspValid && !busy && cmdReady, "R9", "single response cycle",
        {rspValid, busy, cmdReady}, 3'b001);
  endtask

  task automatic t_reset();
    chk(tstClk == 0 && tstEn == 0 && tstClr == 0 && tstDin == 0, "R1", "pins after reset",
        {tstClk, tstEn, tstClr}, 0);
    chk(cmdReady && !busy && !rspValid, "R1", "handshake after reset",
        {cmdReady, busy, rspValid}, 3'b100);
  endtask

  task automatic t_write(input logic sel, input logic [7:0] code, input logic [7:0] dat);
    logic [7:0] rsp; int lat;
    clearLogs();
    expSeq(int'(sel), code, dat);
    doCmd(2'd1, sel, code, dat, rsp, lat);
    chk(rsp == dat, "R4", "write monitor byte", rsp, dat);
    chk(lat == LAT_RW, "R6", "write latency", lat, LAT_RW);
    cmpLogs("R2 R3 R7");
  endtask

  task automatic t_read(input logic sel, input logic [7:0] code, input logic [7:0] expect_b);
    logic [7:0] rsp; int lat;
    clearLogs();
    expSeq(int'(sel), code, expect_b);
    doCmd(2'd0, sel, code, 8'h00, rsp, lat);
    chk(rsp == expect_b, "R5", "read byte", rsp, expect_b);
    chk(lat == LAT_RW, "R6", "read latency", lat, LAT_RW);
    cmpLogs("R5 R7");
  endtask

  task automatic t_clear(input logic sel);
    logic [7:0] rsp; int lat;
    clearLogs();
    eSetClr(int'(sel), 1'b1);
    doCmd(2'd2, sel, 8'h00, 8'h00, rsp, lat);
    chk(tstClr[sel] == 1'b1, "R8", "clear raised", tstClr[sel], 1);
    chk(lat == LAT_CLR, "R8", "clear raise latency", lat, LAT_CLR);
    eSetClr(int'(sel), 1'b0);
    doCmd(2'd3, sel, 8'h00, 8'h00, rsp, lat);
    chk(tstClr[sel] == 1'b0, "R8", "clear released", tstClr[sel], 0);
    chk(lat == LAT_CLR, "R8", "clear release latency", lat, LAT_CLR);
    cmpLogs("R8");
  endtask

  // R10: second command held valid during the first
  task automatic t_backToBack();
    int readyWhileBusy = 0;
    int guard = 0;
    clearLogs();
    expSeq(0, 8'h31, 8'h6E);
    expSeq(0, 8'h32, 8'h19);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd1; cmdSel = 1'b0; cmdCode = 8'h31; cmdData = 8'h6E;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdCode = 8'h32; cmdData = 8'h19;
    while (!rspValid && guard < 200) begin
      if (cmdReady) readyWhileBusy++;
      @(negedge clk); guard++;
    end
    chk(readyWhileBusy == 0, "R10", "ready while busy", readyWhileBusy, 0);
    chk(rspData == 8'h6E, "R10", "first response uses latched fields", rspData, 8'h6E);
    @(negedge clk);
    chk(cmdReady, "R10", "ready after response", cmdReady, 1);
    @(negedge clk);
    cmdValid = 1'b0;
    guard = 0;
    while (!rspValid && guard < 200) begin @(negedge clk); guard++; end
    chk(rspData == 8'h19, "R10", "held command runs next", rspData, 8'h19);
    @(negedge clk);
    cmpLogs("R10");
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(1'b0, 8'h44, 8'h2B);          // R4
    t_read(1'b0, 8'h44, 8'h2B);           // R5
    t_read(1'b0, 8'h71, 8'h71 ^ 8'hA5);   // R5 untouched register
    t_read(1'b0, 8'h71, 8'h71 ^ 8'hA5);   // R5 write-back kept value
    t_write(1'b1, 8'h62, 8'h5C);          // R7 other port
    t_read(1'b1, 8'h62, 8'h5C);           // R7
    t_read(1'b0, 8'h44, 8'h2B);           // R7 port 0 untouched by port 1
    t_clear(1'b0);                        // R8
    t_clear(1'b1);                        // R8
    t_write(1'b0, 8'h44, 8'hD4);          // R4 overwrite
    t_read(1'b0, 8'h44, 8'hD4);           // R5
    t_backToBack();                       // R10
    t_read(1'b0, 8'h31, 8'h6E);           // R10 first write landed
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule